// File: doc/BRIEF.md
# SPI Master Controller with Selectable Transfer Modes

This block is a register-programmed serial peripheral interface master. Software sets up the frame size, clock polarity, clock phase, clock divisor, slave-select mask and transfer mode while the block is disabled. It then enables the block and moves data through an eight-entry transmit queue and an eight-entry receive queue. Frames of 4 to 16 bits go out most significant bit first. While a transfer is under way, the selected slave-select lines are held low.

There are three transfer modes. Full duplex sends every queued word and keeps every word it receives. Send-only sends queued words and throws away what comes back. Receive-only starts a burst of a preset number of frames when software makes one write of any value to the data register. During that burst the output line stays low. Software reads the status flags and the queue levels by polling.

Top module: `spi_xfer_master`

Register map (word addresses on `bus_addr`):

| Addr | Name | Contents |
|------|------|----------|
| 0 | CFG | [9:8] mode (0 full duplex, 1 send-only, 2 receive-only), [7] polarity, [6] phase, [3:0] frame bits minus one |
| 1 | BURST | receive-only frame count minus one |
| 2 | RUN | [0] enable |
| 4 | SEL | slave-select mask |
| 5 | DIV | clock divisor |
| 8 | TXCNT | transmit queue occupancy |
| 9 | RXCNT | receive queue occupancy |
| 10 | STAT | [0] busy, [1] transmit not full, [2] receive not empty, [3] receive full, [4] collision |
| 12 | DATA | write: push or trigger, read: pop |

## Requirements
- R1: After reset, STAT reads 0x0002, both occupancy registers read 0, every `ss_n` line is high and `sclk` is low.
- R2: Writes to CFG, BURST, DIV and SEL are ignored while RUN[0] is 1. While it is 0 they take effect and read back.
- R3: In full-duplex mode each queued word is sent MSB first, using CFG[3:0]+1 bits. Each received frame enters the receive queue and is read from DATA in arrival order.
- R4: One `sclk` period lasts DIV clock cycles (DIV even, at least 2). Between frames `sclk` rests at CFG[7].
- R5: With CFG[6]=0 the input is sampled on the leading edge of each clock pulse. With CFG[6]=1 it is sampled on the trailing edge. In both cases a looped-back word returns unchanged.
- R6: In send-only mode nothing enters the receive queue.
- R7: In receive-only mode one write to DATA runs BURST+1 frames with `mosi` low. The transmit queue stays empty.
- R8: During a transfer the lines whose SEL bit is 1 are low. All lines are high when the block is not busy.
- R9: STAT[0] stays 1 until the transmit queue is empty and the last frame has been fully shifted.
- R10: The transmit queue holds 8 words. At 8, STAT[1] is 0, a further DATA write is dropped and STAT[4] is set.
- R11: The receive queue holds 8 words. At 8, STAT[3] is 1 and further received frames are dropped.
- R12: Writing 0 to RUN empties both queues, clears STAT[4] and stops the engine. DATA writes while disabled are ignored.
- R13: A DIV value below 2 produces no clock, and queued words stay queued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops DATA) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
A software pop of DATA and the engine's push of a finished frame can land on the same clock edge. The transmit queue can likewise take a software push in the same cycle the engine takes a word from it. The bench provokes both by interleaving DATA writes, STAT polls and DATA reads during a fast (DIV=2) looped-back full-duplex stream. Correctness is judged by the scoreboard: every word must come back exactly once and in order, and the occupancy registers must drain to zero.

// File: rtl/spim_pkg.sv
// Shared constants and types for the SPI master.
// Assumes a 16-bit register bus with word addresses.
package spim_pkg;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG   = 4'd0;
    localparam logic [ADDR_W-1:0] A_BURST = 4'd1;
    localparam logic [ADDR_W-1:0] A_RUN   = 4'd2;
    localparam logic [ADDR_W-1:0] A_SEL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_DIV   = 4'd5;
    localparam logic [ADDR_W-1:0] A_TXCNT = 4'd8;
    localparam logic [ADDR_W-1:0] A_RXCNT = 4'd9;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd10;
    localparam logic [ADDR_W-1:0] A_DATA  = 4'd12;

    typedef enum logic [1:0] {
        MODE_DUPLEX = 2'd0,
        MODE_SEND   = 2'd1,
        MODE_RECV   = 2'd2,
        MODE_NONE   = 2'd3
    } xfer_mode_e;
endpackage

// File: rtl/spim_fifo.sv
// Synchronous queue with occupancy count and flush.
// Assumes pushes when full and pops when empty are dropped by the caller's
// intent; both are also guarded here.
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write port.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end
endmodule

// File: rtl/spim_engine.sv
// Serial shift engine: runs one frame per request, MSB first.
// Assumes half_div (divisor/2) and the frame settings stay constant while
// run is high; a half_div of 0 keeps the engine idle.
module spim_engine #(
    parameter int FW  = 16,
    parameter int HW  = 15,
    localparam int BW = $clog2(FW),
    localparam int EW = BW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [BW-1:0] nbits_m1,
    input  logic [HW-1:0] half_div,
    input  logic          frame_req,
    input  logic [FW-1:0] tx_word,
    output logic          frame_ack,
    output logic          rx_valid,
    output logic [FW-1:0] rx_word,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          active
);
    logic [HW-1:0] hc;
    logic [EW-1:0] edge_idx;
    logic [FW-1:0] sh, rx_sh, rx_next;
    logic          tick, last_edge, sample, shift;

    assign frame_ack = run && !active && frame_req && (half_div != '0);
    assign tick      = active && (hc == half_div - 1'b1);
    assign last_edge = (edge_idx == {nbits_m1, 1'b1});
    assign sample    = tick && (!edge_idx[0] ^ cpha);
    assign shift     = tick && !sample && (edge_idx != '0);
    assign rx_next   = {rx_sh[FW-2:0], miso};
    assign mosi      = active && sh[FW-1];

    // Frame sequencing, clock generation and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            hc       <= '0;
            edge_idx <= '0;
            sh       <= '0;
            rx_sh    <= '0;
            sclk     <= 1'b0;
            rx_valid <= 1'b0;
            rx_word  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!run) begin
                active <= 1'b0;
                sclk   <= cpol;
            end else if (frame_ack) begin
                active   <= 1'b1;
                hc       <= '0;
                edge_idx <= '0;
                sh       <= tx_word << (BW'(FW - 1) - nbits_m1);
                rx_sh    <= '0;
                sclk     <= cpol;
            end else if (!active) begin
                sclk <= cpol;
            end else if (tick) begin
                hc       <= '0;
                sclk     <= !sclk;
                edge_idx <= edge_idx + 1'b1;
                if (sample) rx_sh <= rx_next;
                if (shift)  sh    <= {sh[FW-2:0], 1'b0};
                if (last_edge) begin
                    active   <= 1'b0;
                    rx_valid <= 1'b1;
                    rx_word  <= sample ? rx_next : rx_sh;
                end
            end else begin
                hc <= hc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/spi_xfer_master.sv
// Register-programmed SPI master with duplex, send-only and receive-only
// modes. Assumes software changes settings only while RUN is 0.
module spi_xfer_master
    import spim_pkg::*;
#(
    parameter int FW    = 16,
    parameter int DEPTH = 8,
    parameter int NSS   = 4,
    localparam int BW   = $clog2(FW),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NSS-1:0]    ss_n
);
    logic             en_q, cpol_q, cpha_q, coll_q;
    xfer_mode_e       mode_q;
    logic [BW-1:0]    m1_q;
    logic [FW-1:0]    burst_q;
    logic [BUS_W-1:0] div_q;
    logic [NSS-1:0]   sel_q;
    logic [FW:0]      rx_left;

    logic             cfg_ok, data_wr, flush, frame_req, frame_ack;
    logic             eng_active, rx_valid, busy;
    logic [FW-1:0]    rx_word, tx_dout, rx_dout, tx_word;
    logic [LW-1:0]    tx_level, rx_level;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    assign cfg_ok  = bus_wr && !en_q;
    assign data_wr = bus_wr && en_q && (bus_addr == A_DATA);
    assign flush   = bus_wr && (bus_addr == A_RUN) && !bus_wdata[0];
    assign tx_word = (mode_q == MODE_RECV) ? '0 : tx_dout;
    assign busy    = en_q && (eng_active || !tx_empty || (rx_left != '0));
    assign ss_n    = ~(sel_q & {NSS{busy}});

    // Which source feeds the engine in each mode.
    always_comb begin
        case (mode_q)
            MODE_DUPLEX, MODE_SEND: frame_req = !tx_empty;
            MODE_RECV:              frame_req = (rx_left != '0);
            default:                frame_req = 1'b0;
        endcase
    end

    // Configuration, enable, collision flag and receive burst counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            cpol_q  <= 1'b0;
            cpha_q  <= 1'b0;
            mode_q  <= MODE_DUPLEX;
            m1_q    <= '0;
            burst_q <= '0;
            div_q   <= '0;
            sel_q   <= '0;
            coll_q  <= 1'b0;
            rx_left <= '0;
        end else begin
            if (cfg_ok && bus_addr == A_CFG) begin
                mode_q <= xfer_mode_e'(bus_wdata[9:8]);
                cpol_q <= bus_wdata[7];
                cpha_q <= bus_wdata[6];
                m1_q   <= bus_wdata[BW-1:0];
            end
            if (cfg_ok && bus_addr == A_BURST) burst_q <= bus_wdata[FW-1:0];
            if (cfg_ok && bus_addr == A_DIV)   div_q   <= bus_wdata;
            if (cfg_ok && bus_addr == A_SEL)   sel_q   <= bus_wdata[NSS-1:0];
            if (bus_wr && bus_addr == A_RUN)   en_q    <= bus_wdata[0];
            if (flush) begin
                coll_q  <= 1'b0;
                rx_left <= '0;
            end else begin
                if (data_wr && mode_q != MODE_RECV && tx_full) coll_q <= 1'b1;
                if (data_wr && mode_q == MODE_RECV && rx_left == '0)
                    rx_left <= {1'b0, burst_q} + 1'b1;
                else if (frame_ack && mode_q == MODE_RECV)
                    rx_left <= rx_left - 1'b1;
            end
        end
    end

    // Register read mux.
    always_comb begin
        case (bus_addr)
            A_CFG:   bus_rdata = (BUS_W'({mode_q, cpol_q, cpha_q}) << 6) | BUS_W'(m1_q);
            A_BURST: bus_rdata = BUS_W'(burst_q);
            A_RUN:   bus_rdata = BUS_W'(en_q);
            A_SEL:   bus_rdata = BUS_W'(sel_q);
            A_DIV:   bus_rdata = div_q;
            A_TXCNT: bus_rdata = BUS_W'(tx_level);
            A_RXCNT: bus_rdata = BUS_W'(rx_level);
            A_STAT:  bus_rdata = BUS_W'({coll_q, rx_full, !rx_empty, !tx_full, busy});
            A_DATA:  bus_rdata = rx_empty ? '0 : BUS_W'(rx_dout);
            default: bus_rdata = '0;
        endcase
    end

    spim_fifo #(.W(FW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(data_wr && mode_q != MODE_RECV), .din(bus_wdata[FW-1:0]),
        .pop(frame_ack && mode_q != MODE_RECV), .dout(tx_dout),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.W(FW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(rx_valid && en_q && mode_q != MODE_SEND), .din(rx_word),
        .pop(bus_rd && bus_addr == A_DATA), .dout(rx_dout),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.FW(FW), .HW(BUS_W - 1)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(en_q), .cpol(cpol_q), .cpha(cpha_q),
        .nbits_m1(m1_q), .half_div(div_q[BUS_W-1:1]), .frame_req(frame_req),
        .tx_word(tx_word), .frame_ack(frame_ack), .rx_valid(rx_valid),
        .rx_word(rx_word), .sclk(sclk), .mosi(mosi), .miso(miso),
        .active(eng_active)
    );
endmodule

// File: rtl/spim_chk.sv
// Property checker for the SPI master, bound to every instance.
// Assumes the signal names of spi_xfer_master.
module spim_chk
    import spim_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LW    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              active,
    input logic              sclk,
    input logic              cpol,
    input logic [1:0]        mode,
    input logic [LW-1:0]     tx_level,
    input logic [LW-1:0]     rx_level,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wbit0,
    input logic [BUS_W-1:0]  div
);
    // R10
    tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LW'(DEPTH));

    // R11
    rx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= LW'(DEPTH));

    // R6
    send_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && mode == 2'd1 && $past(en && mode == 2'd1)) |-> rx_level <= $past(rx_level));

    // R12
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RUN && !wbit0) |=> (tx_level == '0 && rx_level == '0 && !active));

    // R2
    div_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIV && en) |=> $stable(div));

    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $stable(cpol)) |-> sclk == cpol);

    // R13
    no_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div[BUS_W-1:1] == '0) |-> !active);
endmodule

bind spi_xfer_master spim_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .active(eng_active), .sclk(sclk),
    .cpol(cpol_q), .mode(mode_q), .tx_level(tx_level), .rx_level(rx_level),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .wbit0(bus_wdata[0]), .div(div_q)
);

// File: tb/spi_xfer_master_bench.sv
module spi_xfer_master_bench;
    import spim_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0, bus_rdata;
    logic        sclk, mosi, miso;
    logic [3:0]  ss_n;
    logic        loop_en = 1'b1, miso_fix = 1'b0;

    int n_chk = 0, n_fail = 0;
    int exp_q[$];
    string tag_q[$];
    int got;
    event rx_ev;

    assign miso = loop_en ? mosi : miso_fix;

    always #10 clk = ~clk;

    spi_xfer_master u_spi_xfer_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Driver side of the scoreboard: record an expected received word.
    task automatic expect_rx(input int v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic pop_data();
        int v;
        rd(A_DATA, v);
        got = v;
        ->rx_ev;
    endtask

    task automatic wait_idle(input string req);
        int v;
        for (int i = 0; i < 5000; i++) begin
            rd(A_STAT, v);
            if (v[0] == 1'b0) return;
        end
        check(req, 1, 0);
    endtask

    // Monitor: compare every popped word against the expected queue.
    initial begin
        forever begin
            @(rx_ev);
            if (exp_q.size() == 0) begin
                check("R3 unexpected word", got, -1);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, got, e);
            end
        end
    endtask_dummy_guard: begin end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    logic [7:0] cap_bits;
    realtime    t0, t1;
    logic       cap_done = 1'b0;

    initial begin
        int v, nread;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_STAT, v);  check("R1 status", v, 'h2);
        rd(A_TXCNT, v); check("R1 tx count", v, 0);
        rd(A_RXCNT, v); check("R1 rx count", v, 0);
        check("R1 ss_n", int'(ss_n), 'hF);
        check("R1 sclk", int'(sclk), 0);

        // Duplex, 8-bit, polarity 0 phase 0, divisor 4, lines 0 and 2
        wr(A_CFG, 16'h0007);
        wr(A_DIV, 16'd4);
        wr(A_SEL, 16'h5);
        wr(A_RUN, 16'h1);
        // R2 locked while running
        wr(A_CFG, 16'h02CB);
        wr(A_DIV, 16'd8);
        rd(A_CFG, v); check("R2 cfg locked", v, 'h0007);
        rd(A_DIV, v); check("R2 div locked", v, 4);

        fork
            begin
                for (int i = 0; i < 8; i++) begin
                    @(posedge sclk);
                    if (i == 0) t0 = $realtime;
                    if (i == 1) t1 = $realtime;
                    #1 cap_bits = {cap_bits[6:0], mosi};
                end
                cap_done = 1'b1;
            end
        join_none
        wr(A_DATA, 16'h00A5); expect_rx('hA5, "R3 word0");
        wr(A_DATA, 16'h003C); expect_rx('h3C, "R3 word1");
        wr(A_DATA, 16'h01F0); expect_rx('hF0, "R3 word2 masked to 8 bits");
        #1 check("R8 ss_n active", int'(ss_n), 'hA);
        wait (cap_done);
        check("R3 msb first", int'(cap_bits), 'hA5);
        check("R4 period", int'(t1 - t0), 80);
        wait_idle("R9 idle timeout");
        check("R8 ss_n released", int'(ss_n), 'hF);
        rd(A_RXCNT, v); check("R3 rx count", v, 3);
        repeat (3) pop_data();

        // R5 / R4 polarity 1 phase 1, 12-bit frames
        wr(A_RUN, 16'h0);
        wr(A_CFG, 16'h00CB);
        rd(A_CFG, v); check("R2 cfg accepted", v, 'h00CB);
        wr(A_RUN, 16'h1);
        repeat (2) @(negedge clk);
        check("R4 idle high", int'(sclk), 1);
        wr(A_DATA, 16'hFABC); expect_rx('hABC, "R5 phase1 word0");
        wr(A_DATA, 16'h0123); expect_rx('h123, "R5 phase1 word1");
        wait_idle("R5 idle timeout");
        check("R4 idle high after", int'(sclk), 1);
        repeat (2) pop_data();

        // R5 phase 1 polarity 0, 4-bit frames
        wr(A_RUN, 16'h0);
        wr(A_CFG, 16'h0043);
        wr(A_RUN, 16'h1);
        wr(A_DATA, 16'h0009); expect_rx('h9, "R5 4-bit frame");
        wait_idle("R5 idle timeout");
        pop_data();

        // R6 send-only and R9 busy
        wr(A_RUN, 16'h0);
        wr(A_CFG, 16'h0107);
        wr(A_RUN, 16'h1);
        wr(A_DATA, 16'h0055);
        wr(A_DATA, 16'h00AA);
        rd(A_STAT, v); check("R9 busy with queued words", v & 1, 1);
        for (int i = 0; i < 500; i++) begin
            rd(A_TXCNT, v);
            if (v == 0) break;
        end
        rd(A_STAT, v); check("R9 busy while last frame shifts", v & 1, 1);
        wait_idle("R9 idle timeout");
        rd(A_RXCNT, v); check("R6 nothing received", v, 0);

        // R7 receive-only burst of 5
        wr(A_RUN, 16'h0);
        wr(A_CFG, 16'h0207);
        wr(A_BURST, 16'd4);
        loop_en = 1'b0; miso_fix = 1'b1;
        wr(A_RUN, 16'h1);
        wr(A_DATA, 16'h0077);
        rd(A_TXCNT, v); check("R7 tx queue untouched", v, 0);
        repeat (10) @(negedge clk);
        check("R7 mosi low", int'(mosi), 0);
        wait_idle("R7 idle timeout");
        rd(A_RXCNT, v); check("R7 burst count", v, 5);
        for (int i = 0; i < 5; i++) begin
            expect_rx('hFF, "R7 burst word");
            pop_data();
        end
        loop_en = 1'b1;

        // R13 / R10 no clock, fill the transmit queue
        wr(A_RUN, 16'h0);
        wr(A_CFG, 16'h0107);
        wr(A_DIV, 16'd0);
        wr(A_RUN, 16'h1);
        for (int i = 0; i < 9; i++) wr(A_DATA, 16'(i));
        repeat (20) @(negedge clk);
        check("R13 no clock", int'(sclk), 0);
        rd(A_TXCNT, v); check("R10 tx full count", v, 8);
        rd(A_STAT, v);  check("R10 not-full clear, collision set", v & 'h12, 'h10);
        // R12 flush
        wr(A_RUN, 16'h0);
        rd(A_TXCNT, v); check("R12 tx flushed", v, 0);
        rd(A_STAT, v);  check("R12 collision cleared", v & 'h10, 0);
        wr(A_DATA, 16'h1234);
        rd(A_TXCNT, v); check("R12 write while disabled ignored", v, 0);

        // R11 receive queue overflow
        wr(A_CFG, 16'h0007);
        wr(A_DIV, 16'd2);
        wr(A_RUN, 16'h1);
        for (int i = 0; i < 8; i++) begin
            wr(A_DATA, 16'(8'h10 + i));
            expect_rx(8'h10 + i, "R11 kept word");
        end
        wait_idle("R11 idle timeout");
        wr(A_DATA, 16'h00EE);
        wr(A_DATA, 16'h00DD);
        wait_idle("R11 idle timeout");
        rd(A_RXCNT, v); check("R11 rx count capped", v, 8);
        rd(A_STAT, v);  check("R11 rx full flag", v & 'h8, 'h8);
        repeat (8) pop_data();

        // Concurrent push/pop on both queues
        nread = 0;
        for (int i = 0; i < 6; i++) begin
            wr(A_DATA, 16'(8'h61 + 3 * i));
            expect_rx(8'h61 + 3 * i, "R3 concurrent stream");
            rd(A_STAT, v);
            if (v[2]) begin pop_data(); nread++; end
        end
        for (int i = 0; i < 2000 && nread < 6; i++) begin
            rd(A_STAT, v);
            if (v[2]) begin pop_data(); nread++; end
        end
        check("R3 all stream words read", nread, 6);
        rd(A_RXCNT, v); check("R3 rx drained", v, 0);
        check("R3 scoreboard empty", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule